// File: doc/BRIEF.md
# Four-Phase Instruction Sequencer

This block is the timing backbone of a small processor core. It divides the input clock into four one-hot phase strobes, Q1 to Q4, and one pass through all four is one instruction cycle. It runs a two-stage pipeline: program memory is read at one address while the word fetched in the previous instruction cycle sits in the instruction register for an external decoder. It also produces the data-memory operand-read and result-write strobes, at fixed phases of the instruction cycle.

Program memory is byte addressed and holds 16-bit words, so the sequential address steps by two. When the executing instruction requests a branch at the end of its Q4, the next fetch goes to the target address. The word already fetched behind the branch is squashed, and the execute stage runs a forced no-operation for one instruction cycle. A flush output marks that cycle. The decoder, ALU, register file and memories all lie outside the block.

Top module: `qseq_top`

## Requirements
- R1: `q_phase` is one-hot with bit 0 = Q1, bit 1 = Q2, bit 2 = Q3 and bit 3 = Q4. Each phase lasts one clock, and the order Q1, Q2, Q3, Q4 repeats. While reset is active, Q1 is held.
- R2: `clk_out` is low during Q1 and Q2 and high during Q3 and Q4.
- R3: The program counter `pc_out` is incremented at the end of Q1. From Q2 through Q4 it equals the current fetch address plus 2.
- R4: `imem_addr` is constant for a whole instruction cycle. `imem_rdata` is captured on the clock edge that begins Q4. The captured word appears on `ir_word` from Q1 of the next instruction cycle and holds for that whole cycle.
- R5: Without branches, successive instruction cycles fetch successive addresses 0, 2, 4, and so on. One new word enters the execute stage every instruction cycle.
- R6: `dmem_rd` is high only in Q2, and `dmem_wr` only in Q4, of an instruction cycle whose execute stage holds a valid word.
- R7: `br_req` high at the end of Q4 of a valid execute cycle makes the next instruction cycle fetch from `br_target`. The word fetched in the branch's own cycle is discarded, so a branch costs two instruction cycles.
- R8: `flush` is high for the whole instruction cycle in which the execute stage holds a discarded word or is empty. `dmem_rd` and `dmem_wr` stay low throughout that cycle.
- R9: `br_req` has no effect when it is sampled in Q1, Q2 or Q3, or during a flushed cycle.
- R10: Reset is asynchronous and active low, and its release takes effect after two clock edges. Reset gives Q1, a program counter of 0 and a fetch address of 0, with `flush` high. The first instruction cycle therefore executes a no-operation while address 0 is fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | ADDR_W | Program-memory byte address of the current fetch |
| imem_rdata | input | WORD_W | Program-memory read data |
| pc_out | output | ADDR_W | Program counter |
| ir_word | output | WORD_W | Instruction register, to the decoder |
| q_phase | output | 4 | One-hot phase strobes, bit 0 = Q1 |
| clk_out | output | 1 | Quarter-rate clock, high in Q3 and Q4 |
| dmem_rd | output | 1 | Data-memory operand-read strobe |
| dmem_wr | output | 1 | Data-memory result-write strobe |
| br_req | input | 1 | Branch request from the executing instruction |
| br_target | input | ADDR_W | Branch target byte address |
| flush | output | 1 | Execute stage holds a forced no-operation |

## Verification
Each result has a fixed delay from its stimulus:

- A word offered on `imem_rdata` appears on `ir_word` from the Q1 that follows its fetch cycle.
- A branch sampled at the end of Q4 changes `imem_addr` and raises `flush` from the very next clock.
- `pc_out` takes its new value one clock after Q1.

The bench keeps an instruction-cycle model of the fetch address, instruction word and slot validity, and advances it once per four clocks. It compares every output at the falling edge of each phase, so every register stage has already settled. Branch requests are driven in every phase, and the bench expects only the Q4 samples from valid cycles to have any effect.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  localparam int NUM_PHASES = 4;

endpackage

// File: rtl/qseq_phase_gen.sv
module qseq_phase_gen
  import qseq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  output phase_e                ph,
  output logic [NUM_PHASES-1:0] q_strobe,
  output logic                  qclk
);

  phase_e ph_nxt;

  always_comb begin
    ph_nxt = phase_e'(ph + 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_Q1;
    else        ph <= ph_nxt;
  end

  for (genvar gi = 0; gi < NUM_PHASES; gi++) begin : g_strobe
    assign q_strobe[gi] = (ph == phase_e'(gi));
  end

  // the upper phase bit separates Q1/Q2 from Q3/Q4
  assign qclk = ph[1];

endmodule

// File: rtl/qseq_pc_unit.sv
module qseq_pc_unit
  import qseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STEP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            ph,
  input  logic              take,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W-1:0] pc
);

  logic              pc_en, fa_en;
  logic [ADDR_W-1:0] pc_nxt, fa_nxt;

  always_comb begin
    pc_en  = (ph == PH_Q1);
    fa_en  = (ph == PH_Q4);
    pc_nxt = fetch_addr + ADDR_W'(STEP);
    fa_nxt = take ? target : pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc         <= '0;
      fetch_addr <= '0;
    end else begin
      if (pc_en) pc         <= pc_nxt;
      if (fa_en) fetch_addr <= fa_nxt;
    end
  end

endmodule

// File: rtl/qseq_pipe.sv
module qseq_pipe
  import qseq_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            ph,
  input  logic [WORD_W-1:0] rdata,
  input  logic              br_req,
  output logic              take,
  output logic              ex_valid,
  output logic [WORD_W-1:0] ir
);

  logic [WORD_W-1:0] hold;
  logic              hold_en, ir_en, ex_valid_nxt;

  always_comb begin
    hold_en      = (ph == PH_Q3);
    ir_en        = (ph == PH_Q4);
    take         = ir_en & br_req & ex_valid;
    ex_valid_nxt = ~take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold     <= '0;
      ir       <= '0;
      ex_valid <= 1'b0;
    end else begin
      if (hold_en) hold <= rdata;
      if (ir_en) begin
        ir       <= hold;
        ex_valid <= ex_valid_nxt;
      end
    end
  end

endmodule

// File: rtl/qseq_top.sv
module qseq_top
  import qseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] imem_addr,
  input  logic [WORD_W-1:0] imem_rdata,
  output logic [ADDR_W-1:0] pc_out,
  output logic [WORD_W-1:0] ir_word,
  output logic [3:0]        q_phase,
  output logic              clk_out,
  output logic              dmem_rd,
  output logic              dmem_wr,
  input  logic              br_req,
  input  logic [ADDR_W-1:0] br_target,
  output logic              flush
);

  localparam int STEP = WORD_W / 8;

  logic   rst_meta_n, rst_q_n;
  phase_e ph;
  logic   take, ex_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  qseq_phase_gen u_phase (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .ph       (ph),
    .q_strobe (q_phase),
    .qclk     (clk_out)
  );

  qseq_pc_unit #(.ADDR_W(ADDR_W), .STEP(STEP)) u_pc (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .ph         (ph),
    .take       (take),
    .target     (br_target),
    .fetch_addr (imem_addr),
    .pc         (pc_out)
  );

  qseq_pipe #(.WORD_W(WORD_W)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .ph       (ph),
    .rdata    (imem_rdata),
    .br_req   (br_req),
    .take     (take),
    .ex_valid (ex_valid),
    .ir       (ir_word)
  );

  assign flush   = ~ex_valid;
  assign dmem_rd = ex_valid & q_phase[1];
  assign dmem_wr = ex_valid & q_phase[3];

endmodule

// File: rtl/qseq_chk.sv
module qseq_chk #(
  parameter int ADDR_W = 16,
  parameter int STEP   = 2
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic [3:0]        q_phase,
  input logic              clk_out,
  input logic              dmem_rd,
  input logic              dmem_wr,
  input logic              flush,
  input logic              br_req,
  input logic [ADDR_W-1:0] br_target,
  input logic [ADDR_W-1:0] imem_addr,
  input logic [ADDR_W-1:0] pc_out
);

  // R1
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $countones(q_phase) == 1);

  // R1
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    q_phase[3] |=> q_phase[0]);

  // R2
  qclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(clk_out) |-> q_phase[2]);

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    q_phase[0] |=> pc_out == $past(imem_addr) + ADDR_W'(STEP));

  // R6
  rd_phase_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    dmem_rd |-> q_phase[1] && !flush);

  // R6
  wr_phase_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    dmem_wr |-> q_phase[3] && !flush);

  // R7
  branch_redirect_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (q_phase[3] && br_req && !flush) |=> flush && imem_addr == $past(br_target));

  // R8
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !q_phase[0] |-> $stable(flush));

endmodule

bind qseq_top qseq_chk #(.ADDR_W(ADDR_W), .STEP(WORD_W / 8)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .q_phase   (q_phase),
  .clk_out   (clk_out),
  .dmem_rd   (dmem_rd),
  .dmem_wr   (dmem_wr),
  .flush     (flush),
  .br_req    (br_req),
  .br_target (br_target),
  .imem_addr (imem_addr),
  .pc_out    (pc_out)
);

// File: tb/test_qseq_top.sv
`timescale 1ns/1ps
module test_qseq_top;

  localparam int AW   = 16;
  localparam int WW   = 16;
  localparam int NCYC = 240;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] imem_addr, pc_out, br_target;
  logic [WW-1:0] imem_rdata, ir_word;
  logic [3:0]    q_phase;
  logic          clk_out, dmem_rd, dmem_wr, br_req, flush;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [WW-1:0] word_at(input logic [AW-1:0] a);
    return a ^ 16'hB6C3;
  endfunction

  assign imem_rdata = word_at(imem_addr);

  qseq_top #(.ADDR_W(AW), .WORD_W(WW)) i_qseq_top (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .pc_out(pc_out), .ir_word(ir_word), .q_phase(q_phase), .clk_out(clk_out),
    .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .br_req(br_req),
    .br_target(br_target), .flush(flush)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] exp_fa  = '0;
    logic [WW-1:0] exp_ir  = '0;
    bit            exp_ok  = 1'b0;
    rst_n     = 1'b0;
    br_req    = 1'b0;
    br_target = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk(q_phase == 4'b0001, "R10 phase", q_phase, 1);
    chk(pc_out == 0,        "R10 pc", pc_out, 0);
    chk(imem_addr == 0,     "R10 fetch addr", imem_addr, 0);
    chk(flush == 1'b1,      "R10 flush", flush, 1);
    chk({dmem_rd, dmem_wr} == 2'b00, "R10 strobes", {dmem_rd, dmem_wr}, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      bit            dec;
      logic [AW-1:0] tgt;
      bit            take;
      dec = (cyc % 5 == 2) || ((cyc % 5 == 3) && (cyc % 3 == 0)) || (cyc % 7 == 6);
      tgt = AW'((cyc * 38 + 4) & 16'h00FE);
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        chk(q_phase == 4'(1 << p), "R1 phase", q_phase, 1 << p);
        chk(clk_out == (p >= 2), "R2 clk_out", clk_out, p >= 2);
        chk(imem_addr == exp_fa, "R4/R5/R7/R9 fetch addr", imem_addr, exp_fa);
        chk(ir_word == exp_ir, "R4 ir_word", ir_word, exp_ir);
        chk(flush == !exp_ok, "R8 flush", flush, !exp_ok);
        chk(dmem_rd == (exp_ok && p == 1), "R6/R8 dmem_rd", dmem_rd, exp_ok && p == 1);
        chk(dmem_wr == (exp_ok && p == 3), "R6/R8 dmem_wr", dmem_wr, exp_ok && p == 3);
        if (p > 0)
          chk(pc_out == exp_fa + 2, "R3 pc", pc_out, exp_fa + 2);
        if (p < 3) begin
          // R9: requests sampled in Q1..Q3 must be ignored
          br_req    = 1'b1;
          br_target = 16'hFFFE;
        end else begin
          br_req    = dec;
          br_target = tgt;
        end
      end
      // R7 / R9: only a Q4 request in a valid cycle redirects
      take   = dec && exp_ok;
      exp_ir = word_at(exp_fa);
      exp_ok = !take;
      exp_fa = take ? tgt : exp_fa + 2;
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule